// File: doc/BRIEF.md
# Row Pointer Sequencer

This block keeps the row pointer for a pixel array that is written one row at a time. The pointer is `ADDR_W` bits wide. At the start of each row cycle, a strobe hands the block a 2-bit command, a row address and a direction flag. The block then updates the pointer. On the next clock it reports whether the row cycle writes a row. The written row is the pointer value shown on `row_o`. The index of the bottom row is set by the parameter `LAST_ROW`, for example 767, 799 or 1079 for the usual array sizes.

The direction flag changes two commands. It reverses the step command, so the pointer counts down instead of up. It also turns the "go home" command into "go to the bottom row". The pointer never wraps. If a step would pass row 0 or `LAST_ROW`, or if a load asks for a row beyond `LAST_ROW`, the pointer keeps its value. In that case no write is reported and a one-cycle range error pulse is raised. The controller driving the block must then reload the pointer explicitly. There is no data stream here, so the block has no valid/ready handshake. Every strobe is accepted on the cycle it is high, and the block never applies back-pressure.

Top module: `row_ptr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `row_o` is 0 and both `wr_o` and `range_err_o` are 0.
- R2: In a cycle where `start_i` is low, the next clock leaves `row_o` unchanged and drives `wr_o` and `range_err_o` to 0, whatever `mode_i`, `addr_i` and `flip_i` carry.
- R3: A strobe with `mode_i` = 2'b00 (idle) leaves `row_o` unchanged, and `wr_o` and `range_err_o` are 0 on the next cycle.
- R4: A strobe with `mode_i` = 2'b01 (step) and `flip_i` = 0, taken when `row_o` < `LAST_ROW`, makes `row_o` one larger on the next cycle with `wr_o` = 1.
- R5: A strobe with `mode_i` = 2'b01 and `flip_i` = 1, taken when `row_o` > 0, makes `row_o` one smaller on the next cycle with `wr_o` = 1.
- R6: A strobe with `mode_i` = 2'b10 (load) and `addr_i` <= `LAST_ROW` sets `row_o` to `addr_i` on the next cycle with `wr_o` = 1, for either value of `flip_i`.
- R7: A strobe with `mode_i` = 2'b11 (home) sets `row_o` to 0 when `flip_i` = 0, or to `LAST_ROW` when `flip_i` = 1, with `wr_o` = 1 on the next cycle.
- R8: A forward step (mode 2'b01, `flip_i` = 0) taken when `row_o` = `LAST_ROW` keeps `row_o` at `LAST_ROW`, does not wrap to 0, drives `wr_o` = 0 and pulses `range_err_o` = 1 on the next cycle.
- R9: A backward step (mode 2'b01, `flip_i` = 1) taken when `row_o` = 0 keeps `row_o` at 0, does not wrap, drives `wr_o` = 0 and pulses `range_err_o` = 1 on the next cycle.
- R10: A load with `addr_i` > `LAST_ROW` leaves `row_o` unchanged, drives `wr_o` = 0 and pulses `range_err_o` = 1 on the next cycle.
- R11: `row_o` never holds a value above `LAST_ROW`.
- R12: `wr_o` and `range_err_o` are never high together. Each is high for exactly the one cycle that follows the strobe that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Row-cycle strobe; the command is taken on the clock where this is high |
| mode_i | input | 2 | Command: 00 idle, 01 step, 10 load, 11 home |
| addr_i | input | ADDR_W | Row address used by the load command |
| flip_i | input | 1 | Direction flag: 1 steps down and sends home to `LAST_ROW` |
| row_o | output | ADDR_W | Current row pointer; this is the written row when `wr_o` is high |
| wr_o | output | 1 | One-cycle pulse: the row cycle writes row `row_o` |
| range_err_o | output | 1 | One-cycle pulse: the command would leave the valid range and was refused |

## Verification
The assertions assume that `mode_i`, `addr_i` and `flip_i` are settled whenever `start_i` is sampled high. They also assume `LAST_ROW` fits in `ADDR_W` bits. Under those conditions the assertions expect the pointer to move only on a strobe cycle. The stimulus changes every input only on the falling clock edge, so each command is stable at the rising edge that samples it. Load addresses are drawn over the whole `ADDR_W` range, which includes values above `LAST_ROW`. Long runs of steps in one direction drive the pointer into both saturation edges.

// File: rtl/row_ptr_pkg.sv
package row_ptr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_STEP = 2'b01,
    MODE_LOAD = 2'b10,
    MODE_HOME = 2'b11
  } row_mode_e;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_INC,
    ACT_DEC,
    ACT_LOAD,
    ACT_FIRST,
    ACT_LAST
  } row_act_e;

endpackage

// File: rtl/row_limit_cmp.sv
module row_limit_cmp #(
  parameter int ADDR_W   = 11,
  parameter int LAST_ROW = 767
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              at_first_o,
  output logic              at_last_o,
  output logic              addr_over_o
);

  localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(LAST_ROW);
  localparam bit FULL_SPAN = (LAST_ROW == (2 ** ADDR_W) - 1);

  assign at_first_o = (ptr_i == '0);
  assign at_last_o  = (ptr_i == LAST_V);

  // When the array fills the whole address space, no load can be out of range.
  generate
    if (FULL_SPAN) begin : g_full
      assign addr_over_o = 1'b0;
    end else begin : g_part
      assign addr_over_o = (addr_i > LAST_V);
    end
  endgenerate

endmodule

// File: rtl/row_cmd_decode.sv
module row_cmd_decode
  import row_ptr_pkg::*;
(
  input  logic      start_i,
  input  row_mode_e mode_i,
  input  logic      flip_i,
  input  logic      at_first_i,
  input  logic      at_last_i,
  input  logic      addr_over_i,
  output row_act_e  act_o,
  output logic      wr_o,
  output logic      err_o
);

  always_comb begin
    act_o = ACT_HOLD;
    wr_o  = 1'b0;
    err_o = 1'b0;
    if (start_i) begin
      unique case (mode_i)
        MODE_IDLE: begin
          act_o = ACT_HOLD;
        end
        MODE_STEP: begin
          if (!flip_i) begin
            if (at_last_i) err_o = 1'b1;
            else begin
              act_o = ACT_INC;
              wr_o  = 1'b1;
            end
          end else begin
            if (at_first_i) err_o = 1'b1;
            else begin
              act_o = ACT_DEC;
              wr_o  = 1'b1;
            end
          end
        end
        MODE_LOAD: begin
          if (addr_over_i) err_o = 1'b1;
          else begin
            act_o = ACT_LOAD;
            wr_o  = 1'b1;
          end
        end
        MODE_HOME: begin
          act_o = flip_i ? ACT_LAST : ACT_FIRST;
          wr_o  = 1'b1;
        end
        default: act_o = ACT_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/row_ptr_reg.sv
module row_ptr_reg
  import row_ptr_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int LAST_ROW = 767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  row_act_e          act_i,
  input  logic              wr_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_o,
  output logic              err_o
);

  localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(LAST_ROW);

  logic [ADDR_W-1:0] ptr_nxt;

  always_comb begin
    unique case (act_i)
      ACT_INC:   ptr_nxt = ptr_o + 1'b1;
      ACT_DEC:   ptr_nxt = ptr_o - 1'b1;
      ACT_LOAD:  ptr_nxt = addr_i;
      ACT_FIRST: ptr_nxt = '0;
      ACT_LAST:  ptr_nxt = LAST_V;
      default:   ptr_nxt = ptr_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o <= '0;
      wr_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      ptr_o <= ptr_nxt;
      wr_o  <= wr_i;
      err_o <= err_i;
    end
  end

  // R4: an increment moves the pointer up by exactly one
  p_inc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_INC) |=> (ptr_o == ADDR_W'($past(ptr_o) + 1'b1)));

  // R5: a decrement moves the pointer down by exactly one
  p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_DEC) |=> (ptr_o == ADDR_W'($past(ptr_o) - 1'b1)));

  // R10: a refused command leaves the pointer where it was
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> $stable(ptr_o));

endmodule

// File: rtl/row_ptr_seq.sv
module row_ptr_seq
  import row_ptr_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int LAST_ROW = 767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              flip_i,
  output logic [ADDR_W-1:0] row_o,
  output logic              wr_o,
  output logic              range_err_o
);

  localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(LAST_ROW);

  logic     at_first;
  logic     at_last;
  logic     addr_over;
  row_act_e act;
  logic     wr_d;
  logic     err_d;

  row_limit_cmp #(
    .ADDR_W  (ADDR_W),
    .LAST_ROW(LAST_ROW)
  ) u_limit (
    .ptr_i      (row_o),
    .addr_i     (addr_i),
    .at_first_o (at_first),
    .at_last_o  (at_last),
    .addr_over_o(addr_over)
  );

  row_cmd_decode u_decode (
    .start_i    (start_i),
    .mode_i     (row_mode_e'(mode_i)),
    .flip_i     (flip_i),
    .at_first_i (at_first),
    .at_last_i  (at_last),
    .addr_over_i(addr_over),
    .act_o      (act),
    .wr_o       (wr_d),
    .err_o      (err_d)
  );

  row_ptr_reg #(
    .ADDR_W  (ADDR_W),
    .LAST_ROW(LAST_ROW)
  ) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .wr_i  (wr_d),
    .err_i (err_d),
    .addr_i(addr_i),
    .ptr_o (row_o),
    .wr_o  (wr_o),
    .err_o (range_err_o)
  );

  // R2: no strobe, no movement and no pulse
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!wr_o && !range_err_o && $stable(row_o)));

  // R3: idle command is a no-op
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 2'b00) |=> (!wr_o && !range_err_o && $stable(row_o)));

  // R6: an in-range load lands on the requested row
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 2'b10 && addr_i <= LAST_V) |=> (wr_o && row_o == $past(addr_i)));

  // R7: home goes to the edge chosen by the flag
  p_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 2'b11) |=> (wr_o && row_o == ($past(flip_i) ? LAST_V : '0)));

  // R8: forward step at the bottom row saturates and flags
  p_sat_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 2'b01 && !flip_i && row_o == LAST_V)
      |=> (range_err_o && !wr_o && row_o == LAST_V));

  // R9: backward step at row 0 saturates and flags
  p_sat_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 2'b01 && flip_i && row_o == '0)
      |=> (range_err_o && !wr_o && row_o == '0));

  // R11: pointer stays inside the array
  p_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    row_o <= LAST_V);

  // R12: write and error pulses exclude each other
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && range_err_o));

endmodule

// File: tb/row_ptr_seq_bench.sv
module row_ptr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int LAST_ROW   = 767;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              flip_i = 1'b0;
  logic [ADDR_W-1:0] row_o;
  logic              wr_o;
  logic              range_err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_ptr_seq #(.ADDR_W(ADDR_W), .LAST_ROW(LAST_ROW)) u_row_ptr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .addr_i     (addr_i),
    .flip_i     (flip_i),
    .row_o      (row_o),
    .wr_o       (wr_o),
    .range_err_o(range_err_o)
  );

  // Behavioural reference model
  int    m_row = 0;
  bit    m_wr  = 0;
  bit    m_err = 0;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_row = 0; m_wr = 0; m_err = 0; m_tag = "R1";
    end else if (!start_i) begin
      m_wr = 0; m_err = 0; m_tag = "R2";
    end else begin
      m_wr = 0; m_err = 0;
      case (mode_i)
        2'b00: m_tag = "R3";
        2'b01: begin
          if (!flip_i) begin
            if (m_row == LAST_ROW) begin m_err = 1; m_tag = "R8"; end
            else begin m_row++; m_wr = 1; m_tag = "R4"; end
          end else begin
            if (m_row == 0) begin m_err = 1; m_tag = "R9"; end
            else begin m_row--; m_wr = 1; m_tag = "R5"; end
          end
        end
        2'b10: begin
          if (int'(addr_i) > LAST_ROW) begin m_err = 1; m_tag = "R10"; end
          else begin m_row = int'(addr_i); m_wr = 1; m_tag = "R6"; end
        end
        default: begin
          m_row = flip_i ? LAST_ROW : 0; m_wr = 1; m_tag = "R7";
        end
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(m_tag, int'(row_o), m_row, "row_o");
      check(m_tag, int'(wr_o), int'(m_wr), "wr_o");
      check(m_tag, int'(range_err_o), int'(m_err), "range_err_o");
      check("R11", int'(row_o <= ADDR_W'(LAST_ROW)), 1, "row_o within range");
      check("R12", int'(wr_o && range_err_o), 0, "write and error together");
    end
  end

  task automatic cmd(input bit s, input logic [1:0] m, input int a, input bit f);
    @(negedge clk);
    #1;
    start_i = s; mode_i = m; addr_i = ADDR_W'(a); flip_i = f;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", int'(row_o), 0, "row_o in reset");
    check("R1", int'(wr_o), 0, "wr_o in reset");
    #1 rst_n = 1'b1;

    // R2: no strobe with busy inputs
    cmd(0, 2'b11, 300, 1);
    cmd(0, 2'b10, 12, 0);
    // R9: backward step at row 0
    cmd(1, 2'b01, 0, 1);
    // R4: forward steps
    for (int i = 0; i < 5; i++) cmd(1, 2'b01, 0, 0);
    // R5: backward steps
    cmd(1, 2'b01, 0, 1);
    cmd(1, 2'b01, 0, 1);
    // R3: idle
    cmd(1, 2'b00, 500, 1);
    // R6: load with either flag
    cmd(1, 2'b10, 766, 1);
    cmd(1, 2'b01, 0, 0);
    // R8: forward step at the last row
    cmd(1, 2'b01, 0, 0);
    cmd(1, 2'b01, 0, 0);
    // R10: out-of-range loads
    cmd(1, 2'b10, LAST_ROW + 1, 0);
    cmd(1, 2'b10, 2047, 1);
    cmd(1, 2'b10, LAST_ROW, 0);
    // R7: home in both directions
    cmd(1, 2'b11, 0, 0);
    cmd(1, 2'b11, 0, 1);
    cmd(1, 2'b01, 0, 1);
    cmd(1, 2'b10, 0, 0);
    cmd(0, 2'b00, 0, 0);

    // Mid-run reset (R1)
    cmd(1, 2'b11, 0, 1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1", int'(row_o), 0, "row_o after mid-run reset");
    #1 rst_n = 1'b1;

    // Random phase with runs of steps to reach both edges
    for (int i = 0; i < 6000; i++) begin
      int r;
      bit dir;
      r = int'($urandom_range(0, 99));
      dir = (i / 900) % 2 == 1;
      if (r < 10)      cmd(0, 2'($urandom), int'($urandom_range(0, 2047)), 1'($urandom));
      else if (r < 15) cmd(1, 2'b00, int'($urandom_range(0, 2047)), 1'($urandom));
      else if (r < 85) cmd(1, 2'b01, 0, dir);
      else if (r < 95) cmd(1, 2'b10, int'($urandom_range(0, 2047)), 1'($urandom));
      else             cmd(1, 2'b11, 0, 1'($urandom));
    end

    cmd(0, 2'b00, 0, 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule